// File: doc/BRIEF.md
# Compressed Page Line Address Generator

This block turns a request for one cache line of a compressed memory page into the memory transfer that fetches it. A page of 64 lines, each 64 bytes, is kept in memory with every line squeezed to the same power-of-two size. The block takes three inputs. The first is the page descriptor: base address, storage type, line size code and page-zero bit. The second is a 6-bit line index. The third is the line's metadata entry: zero bit, exception bit and exception slot. From these it produces the byte address and the length of the transfer.

Compressed pages are laid out in three parts. The packed lines come first. A 64-byte metadata area follows them. After that comes an overflow area that holds, uncompressed, the lines that did not fit the fixed size. A line that is known to be all zero needs no memory access at all. A page stored raw, with storage type 0, is addressed as a plain array of 64-byte lines. The result is registered and appears one cycle after the request strobe.

Top module: `lcp_line_addr_gen`

## Requirements
- R1: `rsp_valid` is high in the cycle after a cycle with `req_valid` high, and low after a cycle with `req_valid` low.
- R2: On a compressed page (storage type not 0), a line with zero and exception bits clear gives address base + index × S and length S. Here S is 8 << size code: code 0 gives 8 B, 1 gives 16 B, 2 gives 32 B and 3 gives 64 B. `rsp_mem_req` is 1 and both flags are 0.
- R3: On a compressed page, a line with its exception bit set and its zero bit clear gives address base + 64 × S + 64 + slot × 64 and length 64. `rsp_exc` is 1 and `rsp_mem_req` is 1.
- R4: When the page-zero bit is set, `rsp_zero` is 1, `rsp_mem_req` is 0 and address and length are 0, whatever the other inputs are.
- R5: On a compressed page, a line zero bit gives the same zero response as R4.
- R6: A zero response takes priority over an exception. `rsp_zero` and `rsp_exc` are never both 1.
- R7: On a page of storage type 0, the address is base + index × 64 and the length is 64. The size code, the line zero bit and the exception bit are ignored.
- R8: While `req_valid` is low, the address, length and flags hold their last values.
- R9: During reset, all outputs are 0.
- R10: Address arithmetic wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| pg_base | input | ADDR_W | Page base byte address |
| pg_type | input | 2 | Storage type, 0 = raw |
| pg_size | input | 2 | Line size code (S = 8 << code) |
| pg_zero | input | 1 | Whole page is zero |
| line_idx | input | 6 | Line number within page |
| md_zero | input | 1 | Line is zero |
| md_exc | input | 1 | Line lives in overflow area |
| md_slot | input | 6 | Overflow slot number |
| rsp_valid | output | 1 | Result valid |
| rsp_addr | output | ADDR_W | Transfer byte address |
| rsp_len | output | 7 | Transfer length in bytes |
| rsp_zero | output | 1 | Line is zero, no access |
| rsp_exc | output | 1 | Line fetched from overflow area |
| rsp_mem_req | output | 1 | Memory access needed |

## Verification
The assertions assume that the descriptor and metadata inputs are stable and meaningful in a cycle where `req_valid` is high. They do not depend on which size code or slot value arrives, since every encoding is legal. The stimulus draws every field from a seeded `$urandom`. It skews the zero and exception bits so that each path is hit often. It also mixes in directed cases: the largest index and slot, the top-of-address wraparound, and zero combined with exception.

// File: rtl/lcp_pkg.sv
package lcp_pkg;
    localparam int LINE_SHIFT = 6;
    localparam int META_BYTES = 64;
    localparam int MIN_SHIFT  = 3;
    localparam int LEN_W      = 7;
    localparam logic [1:0] TYPE_RAW = 2'd0;

    typedef enum logic [1:0] {
        SZ_8B  = 2'd0,
        SZ_16B = 2'd1,
        SZ_32B = 2'd2,
        SZ_64B = 2'd3
    } lsize_e;
endpackage

// File: rtl/lcp_size_decode.sv
module lcp_size_decode
    import lcp_pkg::*;
(
    input  lsize_e             code,
    output logic [2:0]         shift,
    output logic [LEN_W-1:0]   len
);
    always_comb begin
        shift = 3'(MIN_SHIFT) + 3'(code);
        len   = LEN_W'(1) << shift;
    end
endmodule

// File: rtl/lcp_offset_calc.sv
module lcp_offset_calc
    import lcp_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int SLOT_W = 6,
    parameter int OFS_W  = IDX_W + LINE_SHIFT + 2
) (
    input  logic [2:0]        shift,
    input  logic [IDX_W-1:0]  idx,
    input  logic [SLOT_W-1:0] slot,
    input  logic              exc_sel,
    output logic [OFS_W-1:0]  ofs
);
    localparam int LINES = 1 << IDX_W;

    logic [OFS_W-1:0] packed_ofs;
    logic [OFS_W-1:0] data_end;
    logic [OFS_W-1:0] ovf_base;
    logic [OFS_W-1:0] ovf_ofs;

    always_comb begin
        packed_ofs = OFS_W'(idx) << shift;
        data_end   = OFS_W'(LINES) << shift;
        ovf_base   = data_end + OFS_W'(META_BYTES);
        ovf_ofs    = ovf_base + (OFS_W'(slot) << LINE_SHIFT);
        ofs        = exc_sel ? ovf_ofs : packed_ofs;
    end
endmodule

// File: rtl/lcp_line_addr_gen.sv
module lcp_line_addr_gen
    import lcp_pkg::*;
#(
    parameter int ADDR_W = 40,
    parameter int IDX_W  = 6,
    parameter int SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] pg_base,
    input  logic [1:0]        pg_type,
    input  logic [1:0]        pg_size,
    input  logic              pg_zero,
    input  logic [IDX_W-1:0]  line_idx,
    input  logic              md_zero,
    input  logic              md_exc,
    input  logic [SLOT_W-1:0] md_slot,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [LEN_W-1:0]  rsp_len,
    output logic              rsp_zero,
    output logic              rsp_exc,
    output logic              rsp_mem_req
);
    localparam int OFS_W = IDX_W + LINE_SHIFT + 2;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic              zero;
        logic              exc;
        logic              mreq;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    logic             is_raw;
    lsize_e           eff_size;
    logic [2:0]       shift;
    logic [LEN_W-1:0] line_len;
    logic             take_exc;
    logic             take_zero;
    logic [OFS_W-1:0] ofs;

    assign is_raw    = (pg_type == TYPE_RAW);
    assign eff_size  = is_raw ? SZ_64B : lsize_e'(pg_size);
    assign take_zero = pg_zero | (md_zero & ~is_raw);
    assign take_exc  = md_exc & ~is_raw & ~take_zero;

    lcp_size_decode u_size (
        .code  (eff_size),
        .shift (shift),
        .len   (line_len)
    );

    lcp_offset_calc #(
        .IDX_W  (IDX_W),
        .SLOT_W (SLOT_W),
        .OFS_W  (OFS_W)
    ) u_ofs (
        .shift   (shift),
        .idx     (line_idx),
        .slot    (md_slot),
        .exc_sel (take_exc),
        .ofs     (ofs)
    );

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            if (take_zero) begin
                rsp_d.addr = '0;
                rsp_d.len  = '0;
                rsp_d.zero = 1'b1;
                rsp_d.exc  = 1'b0;
                rsp_d.mreq = 1'b0;
            end else begin
                rsp_d.addr = pg_base + ADDR_W'(ofs);
                rsp_d.len  = take_exc ? LEN_W'(1 << LINE_SHIFT) : line_len;
                rsp_d.zero = 1'b0;
                rsp_d.exc  = take_exc;
                rsp_d.mreq = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid   = rsp_q.valid;
    assign rsp_addr    = rsp_q.addr;
    assign rsp_len     = rsp_q.len;
    assign rsp_zero    = rsp_q.zero;
    assign rsp_exc     = rsp_q.exc;
    assign rsp_mem_req = rsp_q.mreq;

    a_r1_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r4_zero_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_zero |-> (!rsp_mem_req && rsp_len == '0));
    a_r3_exc_full_line: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_exc |-> (rsp_mem_req && rsp_len == LEN_W'(64)));
    a_r6_zero_exc_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_zero && rsp_exc));
    a_r8_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> $stable(rsp_addr) && $stable(rsp_len));
    a_r4_page_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pg_zero) |=> rsp_zero);
endmodule

// File: tb/lcp_line_addr_gen_tb.sv
module lcp_line_addr_gen_tb_top;
    localparam int ADDR_W = 40;

    logic              clk = 0;
    logic              rst_n = 0;
    logic              req_valid = 0;
    logic [ADDR_W-1:0] pg_base = '0;
    logic [1:0]        pg_type = '0;
    logic [1:0]        pg_size = '0;
    logic              pg_zero = 0;
    logic [5:0]        line_idx = '0;
    logic              md_zero = 0;
    logic              md_exc = 0;
    logic [5:0]        md_slot = '0;
    logic              rsp_valid;
    logic [ADDR_W-1:0] rsp_addr;
    logic [6:0]        rsp_len;
    logic              rsp_zero, rsp_exc, rsp_mem_req;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    lcp_line_addr_gen #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .pg_base(pg_base), .pg_type(pg_type), .pg_size(pg_size), .pg_zero(pg_zero),
        .line_idx(line_idx), .md_zero(md_zero), .md_exc(md_exc), .md_slot(md_slot),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_len(rsp_len),
        .rsp_zero(rsp_zero), .rsp_exc(rsp_exc), .rsp_mem_req(rsp_mem_req)
    );

    // expected result packed as {addr, len, zero, exc, mreq}
    function automatic logic [ADDR_W+9:0] model(
        input logic [ADDR_W-1:0] b, input logic [1:0] t, input logic [1:0] s,
        input logic pz, input logic [5:0] ix, input logic lz, input logic le,
        input logic [5:0] sl);
        longint sz;
        logic [ADDR_W-1:0] a;
        if (pz || (t != 0 && lz)) return {{ADDR_W{1'b0}}, 7'd0, 1'b1, 1'b0, 1'b0};
        if (t == 0) begin
            a = b + ADDR_W'(longint'(ix) * 64);
            return {a, 7'd64, 1'b0, 1'b0, 1'b1};
        end
        sz = longint'(8) << s;
        if (le) begin
            a = b + ADDR_W'(64 * sz + 64 + longint'(sl) * 64);
            return {a, 7'd64, 1'b0, 1'b1, 1'b1};
        end
        a = b + ADDR_W'(longint'(ix) * sz);
        return {a, 7'(sz), 1'b0, 1'b0, 1'b1};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run(input string req, input logic [ADDR_W-1:0] b, input logic [1:0] t,
                       input logic [1:0] s, input logic pz, input logic [5:0] ix,
                       input logic lz, input logic le, input logic [5:0] sl);
        logic [ADDR_W+9:0] e;
        e = model(b, t, s, pz, ix, lz, le, sl);
        pg_base = b; pg_type = t; pg_size = s; pg_zero = pz;
        line_idx = ix; md_zero = lz; md_exc = le; md_slot = sl;
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        check({req, " R1 valid"}, 64'(rsp_valid), 64'd1);
        check({req, " addr"}, 64'(rsp_addr), 64'(e[ADDR_W+9:10]));
        check({req, " len"}, 64'(rsp_len), 64'(e[9:3]));
        check({req, " flags"}, 64'({rsp_zero, rsp_exc, rsp_mem_req}), 64'(e[2:0]));
    endtask

    initial begin : watchdog
        #1500000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [ADDR_W-1:0] held;
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 reset", 64'({rsp_valid, rsp_zero, rsp_exc, rsp_mem_req, rsp_len, rsp_addr}), 64'd0);
        rst_n = 1;
        @(negedge clk);
        check("R1 idle", 64'(rsp_valid), 64'd0);
        // directed
        run("R2 normal max idx", 40'h10_0000_0000, 2'd1, 2'd0, 0, 6'd63, 0, 0, 6'd0);
        run("R2 normal 32B", 40'h00_0000_8000, 2'd2, 2'd2, 0, 6'd5, 0, 0, 6'd9);
        run("R3 exc max slot", 40'h00_1234_0000, 2'd1, 2'd3, 0, 6'd7, 0, 1, 6'd63);
        run("R3 exc 8B", 40'h00_0000_2000, 2'd3, 2'd0, 0, 6'd0, 0, 1, 6'd0);
        run("R4 page zero", 40'h00_0000_4000, 2'd1, 2'd1, 1, 6'd3, 0, 1, 6'd2);
        run("R5 line zero", 40'h00_0000_4000, 2'd1, 2'd1, 0, 6'd3, 1, 0, 6'd2);
        run("R6 zero over exc", 40'h00_0000_4000, 2'd2, 2'd1, 0, 6'd3, 1, 1, 6'd2);
        run("R7 raw ignores bits", 40'h00_0000_1000, 2'd0, 2'd0, 0, 6'd10, 1, 1, 6'd4);
        run("R10 wrap", 40'hFF_FFFF_FF00, 2'd1, 2'd3, 0, 6'd63, 0, 1, 6'd63);
        // R8 hold
        held = rsp_addr;
        pg_base = 40'h55; line_idx = 6'd1;
        @(negedge clk);
        check("R8 hold addr", 64'(rsp_addr), 64'(held));
        check("R1 low after idle", 64'(rsp_valid), 64'd0);
        // random
        for (int i = 0; i < 400; i++) begin
            run("R2-R7 random", {$urandom, $urandom} & {ADDR_W{1'b1}}, 2'($urandom),
                2'($urandom), ($urandom % 8) == 0, 6'($urandom), ($urandom % 6) == 0,
                ($urandom % 3) == 0, 6'($urandom));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule